// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a bit-serial configuration store that feeds a programmable logic device loading itself in master serial mode. The loading device supplies the configuration clock and samples one bit per rising edge. The block answers with the bit at its current address and steps to the next address on that edge. The serial data output is given as a data bit plus a drive enable, so that several readers can share one data line.

Readers are chained by connecting the active-low chain-enable output of one to the active-low chip-enable input of the next. When the first reader has delivered its last bit, it releases the line and pulls its chain output low. The next reader then takes over the line on the following bit, with no gap and no overlap. A single combined reset/output-enable input clears the address when it is at its reset level and lets the output drive when it is at the other level. Which level resets is fixed by a stored setting (a parameter).

A power-up reset input models the supply coming up. A ready output stays low for a fixed number of clocks after that reset is released. A serial-enable input, when low, selects programming mode, and in that mode the reader only withdraws its data drive. The storage content is computed at elaboration, so simulations have a known bitstream.

Top module: `cfgrom_reader`

## Requirements
- R1: While `data_oe` is high, `data_out` equals the stored bit at the current address. The current address is the number of advancing edges since the address was last cleared. The stored bit at address a is the XOR of all bits of ((a zero-extended to 32 bits) XOR SEED) AND 32'h2D5B96A7.
- R2: When `rst_oe` is at the reset level, `data_oe` is low at once, whatever `ce_n` is. Every rising edge sampled in that condition clears the address to 0 and leaves the end-of-array state.
- R3: While `ce_n` is high, `data_oe` is low and the address does not change on clock edges.
- R4: With `ready` high, `ce_n` low, `rst_oe` at the enable level and the array not yet exhausted, every rising edge advances the address by one. `data_oe` is high in this state whenever `ser_en` is high.
- R5: An advancing edge taken at address DEPTH-1 puts the reader in the end-of-array state. In that state `data_oe` is low, the address holds, and no edge advances it until it is cleared.
- R6: `chain_n` is low only when the reader is in the end-of-array state, `ce_n` is low and `rst_oe` is at the enable level. In the end-of-array state it follows `ce_n` while the enable level holds. After a clear it stays high until the whole array has been read again.
- R7: `ser_en` low forces `data_oe` low and changes nothing else: address stepping and `chain_n` behave as with `ser_en` high.
- R8: While `pwr_rst` is high, `ready` is low and the address is cleared. `ready` rises on the POR_CYCLES-th rising edge after `pwr_rst` falls. Until then the address stays 0 and `data_oe` is low.
- R9: The reset level of `rst_oe` is the parameter RST_LEVEL (default 0, so low resets and high enables). With RST_LEVEL set to 1 the roles of the two levels are swapped.
- R10: In a chain of two readers, the two `data_oe` outputs are never high together. The bits carried on the shared line are, in order, all DEPTH bits of the first reader followed by all DEPTH bits of the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock from the loading device |
| pwr_rst | input | 1 | Power-up reset, active high, synchronous |
| rst_oe | input | 1 | Combined reset / output enable; reset level set by RST_LEVEL |
| ce_n | input | 1 | Chip enable, active low |
| ser_en | input | 1 | High for read mode; low selects programming mode |
| data_out | output | 1 | Serial data bit, meaningful while data_oe is high |
| data_oe | output | 1 | Drive enable for the shared data line |
| chain_n | output | 1 | Chain-enable to the next reader, active low |
| ready | output | 1 | Low during the power-on period, high afterwards |

## Verification
Two readers with different seeds are chained and read in one continuous stream. The bits taken from the shared line are compared with the concatenation of both computed contents, which separates an off-by-one handoff from a correct one. Standby, mid-stream clears, reset with chip-enable high, chip-enable toggling after the end of the array, and programming-mode windows each break the stream at a different point. Each one shows whether the address holds, restarts or keeps stepping. A third reader built with the opposite reset level is driven on its own, so that a polarity that has been ignored shows up as a wrong drive state.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  // Mask used to compute the elaborated storage content.
  localparam logic [31:0] FILL_MASK = 32'h2D5B_96A7;

  // Handoff state of one reader in a chain.
  typedef enum logic {
    CH_READ  = 1'b0,  // array not yet exhausted
    CH_SPENT = 1'b1   // last bit delivered, line handed on
  } chain_st_e;

  function automatic logic fill_bit(input logic [31:0] addr, input logic [31:0] seed);
    return ^((addr ^ seed) & FILL_MASK);
  endfunction

endpackage

// File: rtl/cfgrom_por.sv
module cfgrom_por #(
  parameter int POR_CYCLES = 4
) (
  input  logic clk,
  input  logic pwr_rst,
  output logic ready
);

  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      cnt_q   <= cnt_q + CW'(1);
      ready_q <= (cnt_q == LAST_CNT);
    end
  end

  assign ready = ready_q;

  // R8: ready never drops without a power-up reset
  ready_hold_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    ready_q |=> ready_q);

endmodule

// File: rtl/cfgrom_array.sv
module cfgrom_array
  import cfgrom_pkg::*;
#(
  parameter int          DEPTH = 2048,
  parameter int          AW    = 11,
  parameter logic [31:0] SEED  = 32'h0
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);

  logic mem [DEPTH];
  logic rd_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = fill_bit(32'(i), SEED);
    end
  end

  // Synchronous read port so the store maps onto block RAM.
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  assign rd_bit = rd_q;

endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
  import cfgrom_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          pwr_rst,
  input  logic          ready,
  input  logic          rst_act,
  input  logic          ce_n,
  output logic [AW-1:0] addr_nx,
  output logic          spent
);

  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  chain_st_e     st_q, st_nx;
  logic          clr, adv;

  assign clr = pwr_rst || !ready || rst_act;
  assign adv = !ce_n;

  always_comb begin
    addr_nx = addr_q;
    st_nx   = st_q;
    if (clr) begin
      addr_nx = '0;
      st_nx   = CH_READ;
    end else if (st_q == CH_READ && adv) begin
      if (addr_q == LAST_A) begin
        st_nx = CH_SPENT;
      end else begin
        addr_nx = addr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      addr_q <= '0;
      st_q   <= CH_READ;
    end else begin
      addr_q <= addr_nx;
      st_q   <= st_nx;
    end
  end

  assign spent = (st_q == CH_SPENT);

  // R2
  rst_clear_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    rst_act |=> (addr_q == '0) && (st_q == CH_READ));

  // R3
  standby_hold_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (ce_n && !clr) |=> $stable(addr_q));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (!clr && adv && st_q == CH_READ && addr_q != LAST_A)
      |=> addr_q == $past(addr_q) + AW'(1));

  // R5
  spent_hold_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (st_q == CH_SPENT && !clr) |=> $stable(addr_q) && st_q == CH_SPENT);

  // R8
  por_clear_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    !ready |=> addr_q == '0);

endmodule

// File: rtl/cfgrom_reader.sv
module cfgrom_reader #(
  parameter int          DEPTH      = 2048,
  parameter int          POR_CYCLES = 4,
  parameter logic        RST_LEVEL  = 1'b0,
  parameter logic [31:0] SEED       = 32'h0
) (
  input  logic cclk,
  input  logic pwr_rst,
  input  logic rst_oe,
  input  logic ce_n,
  input  logic ser_en,
  output logic data_out,
  output logic data_oe,
  output logic chain_n,
  output logic ready
);

  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic          rst_act, oe_act, spent, rd_bit;
  logic [AW-1:0] rd_addr;

  assign rst_act = (rst_oe == RST_LEVEL);
  assign oe_act  = !rst_act;

  cfgrom_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk     (cclk),
    .pwr_rst (pwr_rst),
    .ready   (ready)
  );

  cfgrom_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk     (cclk),
    .pwr_rst (pwr_rst),
    .ready   (ready),
    .rst_act (rst_act),
    .ce_n    (ce_n),
    .addr_nx (rd_addr),
    .spent   (spent)
  );

  cfgrom_array #(.DEPTH(DEPTH), .AW(AW), .SEED(SEED)) u_array (
    .clk     (cclk),
    .rd_addr (rd_addr),
    .rd_bit  (rd_bit)
  );

  // Drive and chain outputs react to the pins without waiting for a clock.
  assign data_out = rd_bit;
  assign data_oe  = ser_en && ready && oe_act && !ce_n && !spent;
  assign chain_n  = !(spent && oe_act && !ce_n);

  // R6: a reader that passes the line on never drives it itself
  handoff_excl_chk: assert property (@(posedge cclk) disable iff (pwr_rst)
    !chain_n |-> !data_oe);

endmodule

// File: tb/cfgrom_reader_test.sv
module cfgrom_reader_test;

  localparam int D  = 16;
  localparam int D2 = 8;
  localparam int P  = 4;
  localparam logic [31:0] S0   = 32'h0000_00A5;
  localparam logic [31:0] S1   = 32'h0000_1234;
  localparam logic [31:0] S2   = 32'h5A5A_0F0F;
  localparam logic [31:0] MASK = 32'h2D5B_96A7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pwr_rst = 1'b1, rst_oe = 1'b1, ce0_n = 1'b0, ser_en = 1'b1;
  logic rst_oe2 = 1'b0, ce2_n = 1'b0;
  logic d0, oe0, ch0, rd0, d1, oe1, ch1, rd1, d2, oe2, ch2, rd2;

  cfgrom_reader #(.DEPTH(D), .POR_CYCLES(P), .RST_LEVEL(1'b0), .SEED(S0)) uut (
    .cclk(clk), .pwr_rst(pwr_rst), .rst_oe(rst_oe), .ce_n(ce0_n), .ser_en(ser_en),
    .data_out(d0), .data_oe(oe0), .chain_n(ch0), .ready(rd0));

  cfgrom_reader #(.DEPTH(D), .POR_CYCLES(P), .RST_LEVEL(1'b0), .SEED(S1)) u_next (
    .cclk(clk), .pwr_rst(pwr_rst), .rst_oe(rst_oe), .ce_n(ch0), .ser_en(ser_en),
    .data_out(d1), .data_oe(oe1), .chain_n(ch1), .ready(rd1));

  cfgrom_reader #(.DEPTH(D2), .POR_CYCLES(P), .RST_LEVEL(1'b1), .SEED(S2)) u_pol (
    .cclk(clk), .pwr_rst(pwr_rst), .rst_oe(rst_oe2), .ce_n(ce2_n), .ser_en(ser_en),
    .data_out(d2), .data_oe(oe2), .chain_n(ch2), .ready(rd2));

  int  vecs = 0, fails = 0;
  int  pos[3];
  bit  ended[3];
  int  porc = 0;
  bit  rdy = 1'b0;
  bit  capture = 1'b0;
  bit  line_q[$];

  function automatic bit patb(input int a, input logic [31:0] s);
    return ^((32'(a) ^ s) & MASK);
  endfunction

  function automatic string oe_tag(input int k, input logic ce, input logic oa);
    if (k == 2)    return "R9";
    if (!ser_en)   return "R7";
    if (!rdy)      return "R8";
    if (!oa)       return "R2";
    if (ce)        return "R3";
    if (ended[k])  return "R5";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic eval_dev(input int k, input logic ce, input logic rst, input logic lvl,
                          input logic [31:0] seed, input logic d, input logic oe,
                          input logic ch, input logic rd, output logic eceo);
    logic oa, eoe;
    oa   = (rst != lvl);
    eoe  = ser_en && rdy && oa && !ce && !ended[k];
    eceo = !(ended[k] && oa && !ce);
    chk(oe_tag(k, ce, oa), oe, eoe, "data_oe");
    chk((k == 2) ? "R9" : "R6", ch, eceo, "chain_n");
    chk("R8", rd, rdy, "ready");
    if (eoe && oe === 1'b1) chk((k == 2) ? "R9" : "R1", d, patb(pos[k], seed), "data_out");
  endtask

  task automatic adv_dev(input int k, input logic ce, input logic rst, input logic lvl,
                         input int depth);
    if (pwr_rst || !rdy || rst == lvl) begin
      pos[k]   = 0;
      ended[k] = 1'b0;
    end else if (!ce && !ended[k]) begin
      if (pos[k] == depth - 1) ended[k] = 1'b1;
      else                     pos[k]++;
    end
  endtask

  // Called just after a falling edge with inputs already set.
  task automatic step();
    logic e0, e1, e2;
    #1;
    eval_dev(0, ce0_n, rst_oe, 1'b0, S0, d0, oe0, ch0, rd0, e0);
    eval_dev(1, e0, rst_oe, 1'b0, S1, d1, oe1, ch1, rd1, e1);
    eval_dev(2, ce2_n, rst_oe2, 1'b1, S2, d2, oe2, ch2, rd2, e2);
    chk("R10", oe0 & oe1, 1'b0, "both readers driving");
    if (capture) begin
      if (oe0)      line_q.push_back(d0);
      else if (oe1) line_q.push_back(d1);
    end
    @(posedge clk);
    adv_dev(0, ce0_n, rst_oe, 1'b0, D);
    adv_dev(1, e0, rst_oe, 1'b0, D);
    adv_dev(2, ce2_n, rst_oe2, 1'b1, D2);
    if (pwr_rst) begin
      porc = 0;
      rdy  = 1'b0;
    end else if (!rdy) begin
      porc++;
      if (porc == P) rdy = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      pos[k] = 0;
      ended[k] = 1'b0;
    end
    @(negedge clk);
    // R8: power-up period, then a full chained read
    capture = 1'b1;
    run(3);
    pwr_rst = 1'b0;
    run(P + 2);
    run(2 * D + 4);
    capture = 1'b0;

    // R10: bit-exact handoff across the chain
    vecs++;
    if (line_q.size() != 2 * D) begin
      fails++;
      $display("FAIL R10 stream length: actual %0d expected %0d", line_q.size(), 2 * D);
    end else begin
      for (int i = 0; i < 2 * D; i++) begin
        chk("R10", line_q[i], (i < D) ? patb(i, S0) : patb(i - D, S1), "stream bit");
      end
    end

    // R6: chain output follows chip-enable after the end of the array
    ce0_n = 1'b1; run(2);
    ce0_n = 1'b0; run(2);
    // R2 / R6: clear, then chain output high while reading again
    rst_oe = 1'b0; run(2);
    rst_oe = 1'b1; run(5);
    // R3: standby mid-stream
    ce0_n = 1'b1; run(3);
    ce0_n = 1'b0; run(3);
    // R7: programming mode withdraws drive only
    ser_en = 1'b0; run(3);
    ser_en = 1'b1; run(3);
    // R2: reset with chip-enable high
    ce0_n = 1'b1; rst_oe = 1'b0; run(2);
    rst_oe = 1'b1; run(1);
    ce0_n = 1'b0; run(D + 3);
    // R9: opposite polarity reader
    rst_oe2 = 1'b1; run(2);
    rst_oe2 = 1'b0; run(3);
    ce2_n = 1'b1; run(2);
    ce2_n = 1'b0; run(D2 + 2);
    // R8: second power-up mid-stream
    rst_oe = 1'b0; run(1);
    rst_oe = 1'b1; run(3);
    pwr_rst = 1'b1; run(2);
    pwr_rst = 1'b0; run(P + D + 3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule